// File: doc/BRIEF.md
# Dual-Edge Narrow Link Framer

This block sits between a link-state controller and a four-signal double-data-rate link. The link has one link-state wire and three data wires, and the clock is forwarded alongside them. On the transmit side it takes the requested link state and a stream of 18-bit words. It drives both phases of every wire in each clock: the phase after the rising edge and the phase after the falling edge. On the receive side it takes the two sampled phases of each incoming wire and rebuilds the link state and the words.

A clock cycle carries two link-state bits and six data bits, so one word needs three cycles. No framing bit exists. A word starts on the first Data cycle after any other state, and a modulo-3 slice counter advances on every Data cycle that follows. If the link leaves Data before the third slice of a word, the receiver raises a one-clock resynchronisation request so that the link-state controller can answer with Synching.

The decision to move between states belongs to the controller that drives `txReqState` and watches `rxSyncReq`. This block only frames the words and checks alignment.

Top module: `linkFramer`

## Requirements
- R1: The link-state encoding is Quiet=00, Synching=01, Locked=10 and Data=11, with bit 0 on the rising-phase wire and bit 1 on the falling-phase wire. Because of this encoding the state wire toggles within a cycle only in Synching and Locked. The link-state outputs show `txReqState` one clock after it is sampled.
- R2: Each 6-bit data slice leaves with bits [2:0] on the rising-phase data wires and bits [5:3] on the falling-phase data wires. The receiver uses the same split.
- R3: While Data is requested, a word goes out over three consecutive cycles. Bits [5:0] go first, in the same cycle the line state first shows Data, then bits [11:6], then bits [17:12].
- R4: `txReady` is high, combinationally, exactly when `txReqState` is Data and the next line cycle starts a word. That happens when the line is not in Data, or when the line is showing the third slice of a word. `txWord` is taken in that cycle.
- R5: In every cycle whose line state is not Data, all data wires are driven 0.
- R6: A transmit request that leaves Data mid-word drops the rest of that word. The next entry into Data starts a new word at slice 0.
- R7: A received Data cycle following any non-Data cycle is slice 0. Bits [5:0], [11:6] and [17:12] are filled in that order. `rxWordValid` pulses for one clock, together with the new `rxWord`, in the cycle after the third slice is sampled.
- R8: Uninterrupted received Data produces a new word every three cycles, with no gap.
- R9: A received non-Data cycle that follows Data, after one or two slices of a word, pulses `rxSyncReq` for one clock in the cycle after it. Leaving Data after a whole word does not pulse it.
- R10: Data wires sampled in a non-Data cycle have no effect. `rxWordValid` stays low and `rxWord` keeps its last value.
- R11: `rxLinkState` reports the sampled two-phase state one clock after sampling.
- R12: While reset is held, every output is 0. The line and the receiver report Quiet, and `txReady` is low when Quiet is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one cycle per line cycle |
| rst | input | 1 | Synchronous reset, active high |
| txReqState | input | 2 | Link state to send in the next line cycle |
| txWord | input | 18 | Word to send, taken when txReady is high |
| txReady | output | 1 | txWord is consumed this cycle |
| lineStateRise | output | 1 | Link-state wire, rising phase (bit 0) |
| lineStateFall | output | 1 | Link-state wire, falling phase (bit 1) |
| lineDataRise | output | 3 | Data wires, rising phase (slice bits [2:0]) |
| lineDataFall | output | 3 | Data wires, falling phase (slice bits [5:3]) |
| rxStateRise | input | 1 | Received link-state wire, rising phase |
| rxStateFall | input | 1 | Received link-state wire, falling phase |
| rxDataRise | input | 3 | Received data wires, rising phase |
| rxDataFall | input | 3 | Received data wires, falling phase |
| rxLinkState | output | 2 | Received link state, one clock later |
| rxWord | output | 18 | Last assembled received word |
| rxWordValid | output | 1 | One-clock pulse, rxWord updated |
| rxSyncReq | output | 1 | One-clock pulse, word cut short |

## Verification
Every registered result is due in the cycle after its inputs are sampled: line state, line data, received state, the word pulse, the word itself and the resynchronisation pulse. `txReady` is due in the same cycle as `txReqState`. The bench drives inputs two nanoseconds after a rising edge. It compares the registered outputs at that point, against a model that moved on the same edge. It checks `txReady` one nanosecond after each new drive. Fixed sequences cover exits from Data at slices 0, 1 and 2 on both sides. A biased random stretch then mixes state changes with long runs of Data.

// File: rtl/linkFramerPkg.sv
package linkFramerPkg;

  typedef enum logic [1:0] {
    LS_QUIET  = 2'b00,
    LS_SYNC   = 2'b01,
    LS_LOCKED = 2'b10,
    LS_DATA   = 2'b11
  } linkState_t;

  // slice selector width; WORD_SLICES must not exceed 2**SEL_W
  localparam int SEL_W = 2;

  typedef struct packed {
    logic             txActive;  // line cycle carries data
    logic             txLoad;    // take txWord, send slice 0
    logic [SEL_W-1:0] txSel;     // slice index to put on the line
    logic             rxCapture; // sampled cycle is Data
    logic [SEL_W-1:0] rxSel;     // slice index of the sampled cycle
    logic             rxCommit;  // sampled cycle closes a word
  } ctrlStrobes_t;

endpackage

// File: rtl/linkCtrl.sv
module linkCtrl
  import linkFramerPkg::*;
#(
  parameter int WORD_SLICES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   txReqState,
  input  logic         rxStateRise,
  input  logic         rxStateFall,
  output ctrlStrobes_t strb,
  output logic         txReady,
  output logic         lineStateRise,
  output logic         lineStateFall,
  output logic [1:0]   rxLinkState,
  output logic         rxWordValid,
  output logic         rxSyncReq
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(WORD_SLICES - 1);

  linkState_t       txLine;
  logic [SEL_W-1:0] txPh;
  logic [SEL_W-1:0] txNext;
  logic             txReqD;

  linkState_t       rxCur;
  linkState_t       rxPrev;
  logic [SEL_W-1:0] rxPh;
  logic [SEL_W-1:0] rxIdx;
  logic             rxAbort;

  always_comb begin
    txReqD = (linkState_t'(txReqState) == LS_DATA);
    txNext = ((txLine == LS_DATA) && (txPh != LAST)) ? txPh + 1'b1 : '0;

    rxCur   = linkState_t'({rxStateFall, rxStateRise});
    rxIdx   = (rxPrev == LS_DATA) ? rxPh : '0;
    rxAbort = (rxPrev == LS_DATA) && (rxCur != LS_DATA) && (rxPh != '0);

    strb.txActive  = txReqD;
    strb.txLoad    = txReqD && (txNext == '0);
    strb.txSel     = txNext;
    strb.rxCapture = (rxCur == LS_DATA);
    strb.rxSel     = rxIdx;
    strb.rxCommit  = (rxCur == LS_DATA) && (rxIdx == LAST);
  end

  assign txReady       = strb.txLoad;
  assign lineStateRise = txLine[0];
  assign lineStateFall = txLine[1];
  assign rxLinkState   = rxPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      txLine      <= LS_QUIET;
      txPh        <= '0;
      rxPrev      <= LS_QUIET;
      rxPh        <= '0;
      rxWordValid <= 1'b0;
      rxSyncReq   <= 1'b0;
    end else begin
      txLine      <= linkState_t'(txReqState);
      txPh        <= txReqD ? txNext : '0;
      rxPrev      <= rxCur;
      rxPh        <= (rxCur == LS_DATA) ? ((rxIdx == LAST) ? '0 : rxIdx + 1'b1) : '0;
      rxWordValid <= strb.rxCommit;
      rxSyncReq   <= rxAbort;
    end
  end

  // R4: a word is only taken when Data is requested
  p_ready_needs_data_r4: assert property (@(posedge clk) disable iff (rst)
    txReady |-> (txReqState == 2'b11));

  // R1: a taken word is followed by a Data line cycle
  p_ready_then_data_r1: assert property (@(posedge clk) disable iff (rst)
    txReady |=> (lineStateRise && lineStateFall));

  // R7: a word pulse only follows a Data cycle
  p_valid_in_data_r7: assert property (@(posedge clk) disable iff (rst)
    rxWordValid |-> (rxLinkState == 2'b11));

  // R9: a resync pulse marks an exit from Data
  p_sync_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
    rxSyncReq |-> ((rxLinkState != 2'b11) && ($past(rxLinkState) == 2'b11)));

  // R9: a cut word never completes
  p_sync_excl_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !(rxSyncReq && rxWordValid));

endmodule

// File: rtl/linkDatapath.sv
module linkDatapath
  import linkFramerPkg::*;
#(
  parameter int SLICE_W     = 3,
  parameter int WORD_SLICES = 3,
  localparam int CYC_W      = 2 * SLICE_W,
  localparam int WORD_W     = CYC_W * WORD_SLICES
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] txWord,
  output logic [CYC_W-1:0]  txLineData,
  input  logic [CYC_W-1:0]  rxLineData,
  output logic [WORD_W-1:0] rxWord
);

  localparam int HOLD_W = WORD_W - CYC_W;
  localparam int SEL_N  = 2 ** SEL_W;

  logic [HOLD_W-1:0] txHold;
  logic [CYC_W-1:0]  txSlices [SEL_N];
  logic [HOLD_W-1:0] rxAsm;

  // transmit slice choices: slice 0 straight from the input word
  for (genvar g = 0; g < SEL_N; g++) begin : gTxSel
    if (g == 0) begin : gFirst
      assign txSlices[g] = txWord[CYC_W-1:0];
    end else if (g < WORD_SLICES) begin : gHeld
      assign txSlices[g] = txHold[(g-1)*CYC_W +: CYC_W];
    end else begin : gUnused
      assign txSlices[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txHold     <= '0;
      txLineData <= '0;
    end else begin
      if (strb.txLoad) txHold <= txWord[WORD_W-1:CYC_W];
      txLineData <= strb.txActive ? txSlices[strb.txSel] : '0;
    end
  end

  // receive: one register per leading slice, last slice joins at commit
  for (genvar g = 0; g < WORD_SLICES - 1; g++) begin : gRxSlice
    logic [CYC_W-1:0] sliceReg;
    always_ff @(posedge clk) begin
      if (rst) sliceReg <= '0;
      else if (strb.rxCapture && (strb.rxSel == SEL_W'(g))) sliceReg <= rxLineData;
    end
    assign rxAsm[g*CYC_W +: CYC_W] = sliceReg;
  end

  always_ff @(posedge clk) begin
    if (rst) rxWord <= '0;
    else if (strb.rxCommit) rxWord <= {rxLineData, rxAsm};
  end

  // R3: the first slice of a taken word reaches the line next cycle
  p_load_slice0_r3: assert property (@(posedge clk) disable iff (rst)
    strb.txLoad |=> (txLineData == $past(txWord[CYC_W-1:0])));

  // R7: the last slice of a committed word is the last sampled slice
  p_commit_top_r7: assert property (@(posedge clk) disable iff (rst)
    strb.rxCommit |=> (rxWord[WORD_W-1:HOLD_W] == $past(rxLineData)));

endmodule

// File: rtl/linkFramer.sv
module linkFramer
  import linkFramerPkg::*;
#(
  parameter int SLICE_W     = 3,
  parameter int WORD_SLICES = 3,
  localparam int CYC_W      = 2 * SLICE_W,
  localparam int WORD_W     = CYC_W * WORD_SLICES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        txReqState,
  input  logic [WORD_W-1:0] txWord,
  output logic              txReady,
  output logic              lineStateRise,
  output logic              lineStateFall,
  output logic [SLICE_W-1:0] lineDataRise,
  output logic [SLICE_W-1:0] lineDataFall,
  input  logic              rxStateRise,
  input  logic              rxStateFall,
  input  logic [SLICE_W-1:0] rxDataRise,
  input  logic [SLICE_W-1:0] rxDataFall,
  output logic [1:0]        rxLinkState,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxWordValid,
  output logic              rxSyncReq
);

  ctrlStrobes_t     strb;
  logic [CYC_W-1:0] txLineData;

  linkCtrl #(.WORD_SLICES(WORD_SLICES)) uCtrl (
    .clk          (clk),
    .rst          (rst),
    .txReqState   (txReqState),
    .rxStateRise  (rxStateRise),
    .rxStateFall  (rxStateFall),
    .strb         (strb),
    .txReady      (txReady),
    .lineStateRise(lineStateRise),
    .lineStateFall(lineStateFall),
    .rxLinkState  (rxLinkState),
    .rxWordValid  (rxWordValid),
    .rxSyncReq    (rxSyncReq)
  );

  linkDatapath #(.SLICE_W(SLICE_W), .WORD_SLICES(WORD_SLICES)) uData (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .txWord    (txWord),
    .txLineData(txLineData),
    .rxLineData({rxDataFall, rxDataRise}),
    .rxWord    (rxWord)
  );

  assign lineDataRise = txLineData[SLICE_W-1:0];
  assign lineDataFall = txLineData[CYC_W-1:SLICE_W];

  // R5: data wires stay low outside Data
  p_idle_data_low_r5: assert property (@(posedge clk) disable iff (rst)
    !(lineStateRise && lineStateFall) |-> (lineDataRise == '0 && lineDataFall == '0));

endmodule

// File: tb/tb_linkFramer.sv
module tb_linkFramer;
  localparam int SW = 3;
  localparam int NS = 3;
  localparam int CW = 2 * SW;
  localparam int WW = CW * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]    txReq = '0;
  logic [WW-1:0] txWord = '0;
  logic          txReady;
  logic          lsR, lsF;
  logic [SW-1:0] ldR, ldF;
  logic          rsR = 1'b0, rsF = 1'b0;
  logic [SW-1:0] rdR = '0, rdF = '0;
  logic [1:0]    rxLs;
  logic [WW-1:0] rxWord;
  logic          rxValid, rxSync;

  linkFramer dut (
    .clk(clk), .rst(rst), .txReqState(txReq), .txWord(txWord), .txReady(txReady),
    .lineStateRise(lsR), .lineStateFall(lsF), .lineDataRise(ldR), .lineDataFall(ldF),
    .rxStateRise(rsR), .rxStateFall(rsF), .rxDataRise(rdR), .rxDataFall(rdF),
    .rxLinkState(rxLs), .rxWord(rxWord), .rxWordValid(rxValid), .rxSyncReq(rxSync)
  );

  int total = 0;
  int bad = 0;
  int unsigned seed = 32'h1234_5678;

  // behavioural reference model, advanced on each rising edge
  int mLine, mTxCnt, expLd, mRxPrev, mRxCnt, st;
  int slq[$];
  logic [WW-1:0] mAcc, expRxWord;
  int expValid, expSync;

  always @(posedge clk) begin
    if (rst) begin
      mLine = 0; mTxCnt = 0; slq.delete(); expLd = 0;
      mRxPrev = 0; mRxCnt = 0; mAcc = '0; expRxWord = '0; expValid = 0; expSync = 0;
    end else begin
      if (txReq == 2'd3) begin
        if (mLine != 3 || mTxCnt == NS) begin
          slq.delete();
          for (int k = 0; k < NS; k++) slq.push_back(int'(txWord[k*CW +: CW]));
          mTxCnt = 0;
        end
        expLd = slq.pop_front();
        mTxCnt++;
      end else begin
        slq.delete(); expLd = 0; mTxCnt = 0;
      end
      mLine = int'(txReq);
      st = int'({rsF, rsR});
      expValid = 0; expSync = 0;
      if (st == 3) begin
        if (mRxPrev != 3) mRxCnt = 0;
        mAcc[mRxCnt*CW +: CW] = {rdF, rdR};
        mRxCnt++;
        if (mRxCnt == NS) begin expRxWord = mAcc; expValid = 1; mRxCnt = 0; end
      end else begin
        expSync = (mRxPrev == 3 && mRxCnt != 0) ? 1 : 0;
        mRxCnt = 0;
      end
      mRxPrev = st;
    end
  end

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one line cycle: compare registered results, then drive the next inputs
  task automatic cyc(int req, int rxSt);
    @(posedge clk);
    #2;
    chk("R1 line state", int'({lsF, lsR}), mLine);
    chk("R2/R3/R5/R6 line data", int'({ldF, ldR}), expLd);
    chk("R11 rx state", int'(rxLs), mRxPrev);
    chk("R7/R8 word pulse", int'(rxValid), expValid);
    chk("R7/R10 rx word", int'(rxWord), int'(expRxWord));
    chk("R9 resync pulse", int'(rxSync), expSync);
    txReq = 2'(req);
    txWord = WW'(rnd());
    {rsF, rsR} = 2'(rxSt);
    {rdF, rdR} = CW'(rnd());
    #1;
    chk("R4 ready", int'(txReady),
        (req == 3 && (mLine != 3 || mTxCnt == NS)) ? 1 : 0);
  endtask

  task automatic rep(int n, int req, int rxSt);
    for (int i = 0; i < n; i++) cyc(req, rxSt);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rep(3, 0, 0);
    // R12: reset state at the ports
    chk("R12 line state", int'({lsF, lsR}), 0);
    chk("R12 line data", int'({ldF, ldR}), 0);
    chk("R12 ready", int'(txReady), 0);
    chk("R12 rx state", int'(rxLs), 0);
    chk("R12 rx word", int'(rxWord), 0);
    chk("R12 pulses", int'({rxValid, rxSync}), 0);
    rst = 1'b0;
    rep(2, 0, 0);
    rep(2, 1, 1);
    rep(2, 2, 2);
    rep(9, 3, 3);   // R8: three back-to-back words each way
    rep(1, 2, 2);   // exit after whole word: no resync (R9)
    rep(4, 3, 3);
    rep(1, 2, 2);   // R6 tx abort; R9 rx exit after one slice
    rep(5, 3, 3);
    rep(1, 1, 1);   // R9 rx exit after two slices
    rep(3, 3, 0);   // tx entry from Synching; R10 rx idle data ignored
    rep(2, 0, 2);
    for (int i = 0; i < 400; i++) begin
      int unsigned a = rnd();
      int unsigned b = rnd();
      cyc((a % 8 >= 3) ? 3 : int'(a % 4), (b % 8 >= 3) ? 3 : int'(b % 4));
    end
    rep(3, 0, 0);
    summary();
    $finish;
  end

endmodule